// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the end of decode in an in-order pipeline. Each cycle it decides whether the instruction now presented may go to a functional unit, or whether it has to wait. It holds two pieces of state. The first is one occupancy flag per functional unit class: integer, add, multiply and divide. The second is one pending-write flag per architectural register.

A candidate instruction supplies its unit class, its destination register and two source register indices. The block raises `issue` when every hazard is absent. It raises `stall` when the candidate's unit is occupied, when either source has a write outstanding, or when its destination has a write outstanding. Write-after-read is never tested, because instructions leave decode in program order.

On issue, the unit flag and the destination flag are both set. A writeback strobe with a register index clears the matching pending flag. A per-unit completion vector clears unit flags. Both clears become visible on the following cycle.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every unit flag and every pending flag is clear, so any valid instruction is reported as `issue` (high) with `stall` low.
- R2: A valid instruction whose unit class (0 integer, 1 add, 2 multiply, 3 divide) is occupied gets `stall` high and `issue` low.
- R3: A valid instruction with a pending write on `srcA` or on `srcB` is stalled.
- R4: A valid instruction with a pending write on its destination is stalled.
- R5: A write-after-read situation is not a hazard. An instruction whose destination is a source of an earlier, still-running instruction issues if R2 to R4 allow it.
- R6: Issuing sets the unit's occupied flag and the destination's pending flag, and both take effect from the next cycle on.
- R7: `wbValid` with `wbReg` clears that register's pending flag from the next cycle. Bit u of `unitDone` clears unit u's flag from the next cycle.
- R8: When a clear and a set target the same flag in one cycle, the flag ends up set.
- R9: Register 0 never becomes pending, so reading or writing it never stalls.
- R10: `issue` and `stall` are never high together, and both are low when `instValid` is low. A stalled or invalid instruction changes no flag.
- R11: The decision uses only the registered flags. A clear arriving in the same cycle does not release a stalled instruction until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A decoded instruction is presented |
| instUnit | input | 2 | Unit class: 0 integer, 1 add, 2 multiply, 3 divide |
| instDest | input | 5 | Destination register index |
| instSrcA | input | 5 | First source register index |
| instSrcB | input | 5 | Second source register index |
| wbValid | input | 1 | Writeback strobe |
| wbReg | input | 5 | Register written back |
| unitDone | input | 4 | Per-unit release strobes |
| issue | output | 1 | Candidate issues this cycle |
| stall | output | 1 | Candidate is held this cycle |

## Verification
A directed opening sequence isolates each stall cause in turn: unit occupancy alone, a source conflict alone, and a destination conflict alone. It also places a write-after-read pair so that a spurious hazard check would show up as an extra stall. Further directed cycles put a clear and a set on the same flag, and a writeback on the same cycle as a stalled reader. These separate the set-wins rule and the registered decision from a bypassed decision.

A long arithmetic pseudo-random sweep follows. It draws register indices from a narrow range so that conflicts are dense, and mixes in random release strobes. Each cycle is compared against a flag model kept in the bench.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int SB_UNITS = 4;
  localparam int SB_UNIT_W = $clog2(SB_UNITS);
  localparam int SB_REGS = 32;
  localparam int SB_REG_W = $clog2(SB_REGS);

  typedef logic [SB_REG_W-1:0] regIdx_t;

  typedef enum logic [SB_UNIT_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unitClass_e;

  // strobes from the issue control to the flag datapath
  typedef struct packed {
    logic [SB_UNITS-1:0] setBusy;
    logic                setPend;
    regIdx_t             dest;
  } sbStrobe_t;
endpackage

// File: rtl/sb_ctrl.sv
`timescale 1ns/1ps
module sb_ctrl
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  unitClass_e          instUnit,
  input  regIdx_t             instDest,
  input  regIdx_t             instSrcA,
  input  regIdx_t             instSrcB,
  input  logic [SB_UNITS-1:0] busyQ,
  input  logic [SB_REGS-1:0]  pendQ,
  output logic                issue,
  output logic                stall,
  output sbStrobe_t           strb
);
  logic unitHaz;
  logic rawHaz;
  logic wawHaz;
  logic anyHaz;
  logic [SB_UNITS-1:0] unitSel;

  always_comb begin
    unitHaz = busyQ[instUnit];
    rawHaz  = pendQ[instSrcA] | pendQ[instSrcB];
    wawHaz  = pendQ[instDest];
    anyHaz  = unitHaz | rawHaz | wawHaz;
    issue   = instValid & ~anyHaz;
    stall   = instValid & anyHaz;
  end

  genvar u;
  generate
    for (u = 0; u < SB_UNITS; u++) begin : g_sel
      assign unitSel[u] = (instUnit == unitClass_e'(u));
    end
  endgenerate

  always_comb begin
    strb.setBusy = issue ? unitSel : '0;
    strb.setPend = issue && (instDest != '0);
    strb.dest    = instDest;
  end

  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(issue && stall) && (instValid || (!issue && !stall)));
  // R2
  unit_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> !busyQ[instUnit]);
  // R3
  raw_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> !pendQ[instSrcA] && !pendQ[instSrcB]);
  // R4
  waw_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> !pendQ[instDest]);
endmodule

// File: rtl/sb_state.sv
`timescale 1ns/1ps
module sb_state
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sbStrobe_t           strb,
  input  logic                wbValid,
  input  regIdx_t             wbReg,
  input  logic [SB_UNITS-1:0] unitDone,
  output logic [SB_UNITS-1:0] busyQ,
  output logic [SB_REGS-1:0]  pendQ
);
  logic [SB_UNITS-1:0] busyNext;
  logic [SB_REGS-1:0]  pendNext;

  genvar u, r;
  generate
    for (u = 0; u < SB_UNITS; u++) begin : g_unit
      // set has priority over release
      assign busyNext[u] = strb.setBusy[u] | (busyQ[u] & ~unitDone[u]);
    end
    for (r = 0; r < SB_REGS; r++) begin : g_reg
      if (r == 0) begin : g_zero
        assign pendNext[r] = 1'b0;
      end else begin : g_live
        logic hitSet;
        logic hitClr;
        assign hitSet = strb.setPend && (strb.dest == regIdx_t'(r));
        assign hitClr = wbValid && (wbReg == regIdx_t'(r));
        assign pendNext[r] = hitSet | (pendQ[r] & ~hitClr);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= '0;
      pendQ <= '0;
    end else begin
      busyQ <= busyNext;
      pendQ <= pendNext;
    end
  end

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendQ[0]);
  // R7
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !(strb.setPend && strb.dest == wbReg) |=> !pendQ[$past(wbReg)]);
  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPend |=> pendQ[$past(strb.dest)]);

  generate
    for (u = 0; u < SB_UNITS; u++) begin : g_uchk
      // R6
      busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.setBusy[u] |=> busyQ[u]);
      // R7
      busy_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
        unitDone[u] && !strb.setBusy[u] |=> !busyQ[u]);
    end
  endgenerate
endmodule

// File: rtl/issue_scoreboard.sv
`timescale 1ns/1ps
module issue_scoreboard
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [SB_UNIT_W-1:0] instUnit,
  input  logic [SB_REG_W-1:0] instDest,
  input  logic [SB_REG_W-1:0] instSrcA,
  input  logic [SB_REG_W-1:0] instSrcB,
  input  logic                wbValid,
  input  logic [SB_REG_W-1:0] wbReg,
  input  logic [SB_UNITS-1:0] unitDone,
  output logic                issue,
  output logic                stall
);
  sbStrobe_t           strb;
  logic [SB_UNITS-1:0] busyQ;
  logic [SB_REGS-1:0]  pendQ;

  sb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instUnit  (unitClass_e'(instUnit)),
    .instDest  (instDest),
    .instSrcA  (instSrcA),
    .instSrcB  (instSrcB),
    .busyQ     (busyQ),
    .pendQ     (pendQ),
    .issue     (issue),
    .stall     (stall),
    .strb      (strb)
  );

  sb_state u_state (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wbValid  (wbValid),
    .wbReg    (wbReg),
    .unitDone (unitDone),
    .busyQ    (busyQ),
    .pendQ    (pendQ)
  );
endmodule

// File: tb/tb_issue_scoreboard.sv
`timescale 1ns/1ps
module tb_issue_scoreboard;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [1:0] instUnit = '0;
  logic [4:0] instDest = '0;
  logic [4:0] instSrcA = '0;
  logic [4:0] instSrcB = '0;
  logic       wbValid = 1'b0;
  logic [4:0] wbReg = '0;
  logic [3:0] unitDone = '0;
  logic       issue;
  logic       stall;

  int checks = 0;
  int errors = 0;
  logic mBusy [4];
  logic mPend [32];
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  issue_scoreboard dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instUnit(instUnit),
    .instDest(instDest), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .wbValid(wbValid), .wbReg(wbReg), .unitDone(unitDone),
    .issue(issue), .stall(stall)
  );

  task automatic check(input logic ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: issue/stall actual %b expected %b", tag, act, exp);
    end
  endtask

  // want: -1 = model only, 0 = expect no issue, 1 = expect issue
  task automatic doCycle(input logic v, input logic [1:0] u, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b, input logic wv,
                         input logic [4:0] wr, input logic [3:0] dn,
                         input int want, input string tag);
    logic haz, eIss, eStl;
    string mTag;
    @(negedge clk);
    instValid = v; instUnit = u; instDest = d; instSrcA = a; instSrcB = b;
    wbValid = wv; wbReg = wr; unitDone = dn;
    #1;
    haz  = mBusy[u] | mPend[a] | mPend[b] | mPend[d];
    eIss = v & ~haz;
    eStl = v & haz;
    if (!v) mTag = "R10";
    else if (mBusy[u]) mTag = "R2";
    else if (mPend[a] | mPend[b]) mTag = "R3";
    else if (mPend[d]) mTag = "R4";
    else mTag = "R1";
    check(issue == eIss && stall == eStl, mTag, {issue, stall}, {eIss, eStl});
    if (want >= 0)
      check(issue == want[0] && stall == (v & ~want[0]), tag, {issue, stall},
            {want[0], v & ~want[0]});
    // model update: clears then sets (set wins)
    if (wv) mPend[wr] = 1'b0;
    for (int k = 0; k < 4; k++) if (dn[k]) mBusy[k] = 1'b0;
    if (eIss) begin
      mBusy[u] = 1'b1;
      if (d != 0) mPend[d] = 1'b1;
    end
    @(posedge clk);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) mBusy[k] = 1'b0;
    for (int k = 0; k < 32; k++) mPend[k] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    doCycle(1, 0, 3, 1, 2, 0, 0, 4'h0, 1, "R1");
    // R2 integer unit now occupied
    doCycle(1, 0, 4, 0, 0, 0, 0, 4'h0, 0, "R2");
    // R3 source r3 pending
    doCycle(1, 1, 5, 3, 0, 0, 0, 4'h0, 0, "R3");
    doCycle(1, 1, 5, 0, 3, 0, 0, 4'h0, 0, "R3");
    // R4 destination r3 pending
    doCycle(1, 1, 3, 0, 0, 0, 0, 4'h0, 0, "R4");
    // R5 write to r1, which the first instruction reads
    doCycle(1, 2, 1, 0, 0, 0, 0, 4'h0, 1, "R5");
    // R11 writeback of r1 same cycle does not release reader
    doCycle(1, 1, 6, 1, 0, 1, 1, 4'h0, 0, "R11");
    // R7 released next cycle, R6 add unit and r6 set
    doCycle(1, 1, 6, 1, 0, 0, 0, 4'h0, 1, "R7");
    doCycle(1, 1, 9, 0, 0, 0, 0, 4'h0, 0, "R6");
    doCycle(1, 3, 9, 6, 0, 0, 0, 4'h0, 0, "R6");
    // R8 issue divide to r7 while clearing divide and r7
    doCycle(1, 3, 7, 0, 0, 1, 7, 4'h8, 1, "R8");
    doCycle(1, 3, 0, 0, 0, 0, 0, 4'h1, 0, "R8");
    doCycle(1, 0, 8, 7, 0, 0, 0, 4'h0, 0, "R8");
    // R7 integer unit release verified
    doCycle(1, 0, 8, 0, 0, 0, 0, 4'h0, 1, "R7");
    // R10 invalid cycles, drain state
    doCycle(0, 0, 0, 0, 0, 1, 3, 4'hf, 0, "R10");
    doCycle(0, 0, 0, 0, 0, 1, 1, 4'h0, 0, "R10");
    doCycle(0, 0, 0, 0, 0, 1, 6, 4'h0, 0, "R10");
    doCycle(0, 0, 0, 0, 0, 1, 7, 4'h0, 0, "R10");
    doCycle(0, 0, 0, 0, 0, 1, 8, 4'h0, 0, "R10");
    // R9 register 0 never pending
    doCycle(1, 0, 0, 0, 0, 0, 0, 4'h0, 1, "R9");
    doCycle(1, 1, 0, 0, 0, 0, 0, 4'h0, 1, "R9");
    // R10 stalled instruction leaves flags alone: r4 free afterwards
    doCycle(1, 0, 4, 0, 0, 0, 0, 4'h0, 0, "R10");
    doCycle(1, 2, 5, 4, 4, 0, 0, 4'hf, 1, "R10");
    // sweep over a narrow register window
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      lcg = nextRand(lcg);
      r = lcg;
      doCycle(r[1:0] != 2'b00, r[3:2], {2'b00, r[6:4]}, {2'b00, r[9:7]},
              {2'b00, r[12:10]}, r[13], {2'b00, r[16:14]},
              r[20:17] & r[24:21], -1, "");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule